// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave (2 Kb)

This block is a synthesizable slave for a three-wire serial memory bus. A host drives a select line, a serial clock and a serial data input. The block answers on a serial data output, which comes with a drive-enable so that the pad can tri-state it. A static width input arranges the 256-byte store either as 128 words of 16 bits or as 256 bytes. Each command starts with a start bit, followed by a two-bit opcode and an address field. The block handles single and streaming reads, a write-permission latch that a pair of control codes sets and clears, and a write that commits when select falls and then runs for a fixed busy time.

The bus lines are sampled in the block's own clock domain. A rising serial clock is detected as a low-to-high change between two clock samples. The host must therefore keep each serial clock phase at least two system clocks long and present the lines synchronous to `clk`, or synchronise them first. While select is high after a committed write, the output reports busy or ready.

Top module: `mw_eeprom`

## Requirements
- R1: With `wide16`=1 the address field is 8 bits, its first bit ignored, giving a 7-bit word address. Word A occupies byte 2A as its upper half and byte 2A+1 as its lower half. With `wide16`=0 the field is 9 bits, its first bit ignored, giving an 8-bit byte address.
- R2: A command begins with the first 1 sampled on `sdi` at a rising `sclk` while `sel` is high. The next two bits are the opcode: 10 read, 01 write, 00 control.
- R3: For a read, the rising `sclk` that samples the last address bit enables `sdo` and drives one 0. Each later rising `sclk` presents the next bit of the addressed word, most significant bit first.
- R4: While `sel` stays high, the word after the current one follows with no gap bit, at the next higher address.
- R5: A streaming read moves from the last address of the array (word 127 or byte 255) to address 0.
- R6: With opcode 00, the first two address bits choose the action. 11 sets the write-permission latch and 00 clears it. The other two values leave it unchanged.
- R7: The latch is clear after reset. A write issued while the latch is clear stores nothing and shows no status.
- R8: A write with the latch set stores its data when `sel` falls after all data bits (16 in word mode, 8 in byte mode). A write cut short by `sel` falling stores nothing.
- R9: After a committed write, raising `sel` drives `sdo`=0 until BUSY_CYCLES clocks have passed since the commit, and `sdo`=1 after that.
- R10: Rising `sclk` edges during the busy time start no command. While `sel` is high, the output keeps reporting busy.
- R11: `sdo_en` is 0 whenever `sel` is low. Dropping `sel` abandons any command in progress.
- R12: Reads return stored data whether the latch is set or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also samples the bus lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide16 | input | 1 | 1: 16-bit words, 0: 8-bit bytes (static) |
| sel | input | 1 | Bus select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data / status to the host |
| sdo_en | output | 1 | Drive enable for `sdo` (0 = high impedance) |

## Verification
A fault in the bit or word position counters shows up within one word of a read, as a shifted or repeated bit pattern in the streamed value or a gap where the next word should start. A wrong permission latch shows up on the next write. That write either produces a busy status and overwrites data, or it fails to, and a read-back immediately afterwards reveals which. A wrong busy counter shows up as a status that turns ready too early or stays busy too long, or as a command accepted inside the busy window. The sample points near both ends of the window catch this within a few clocks.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } mw_state_e;

  localparam logic [1:0] OP_CTL = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;

  localparam logic [1:0] CTL_UNLOCK = 2'b11;
  localparam logic [1:0] CTL_LOCK   = 2'b00;

endpackage

// File: rtl/mw_eeprom_array.sv
module mw_eeprom_array #(
  parameter int BYTE_AW = 8
) (
  input  logic               clk,
  input  logic               wide16,
  input  logic [BYTE_AW-1:0] rd_addr,
  input  logic               wr_en,
  input  logic [BYTE_AW-1:0] wr_addr,
  input  logic [15:0]        wr_data,
  output logic [15:0]        rd_word
);
  localparam int NBYTES = 1 << BYTE_AW;

  logic [7:0] mem [NBYTES];

  // upper byte of a word sits at the even byte index
  function automatic logic [BYTE_AW-1:0] hi_idx(input logic [BYTE_AW-1:0] a);
    return {a[BYTE_AW-2:0], 1'b0};
  endfunction

  function automatic logic [BYTE_AW-1:0] lo_idx(input logic [BYTE_AW-1:0] a);
    return {a[BYTE_AW-2:0], 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wide16) begin
        mem[hi_idx(wr_addr)] <= wr_data[15:8];
        mem[lo_idx(wr_addr)] <= wr_data[7:0];
      end else begin
        mem[wr_addr] <= wr_data[7:0];
      end
    end
  end

  always_comb begin
    if (wide16) rd_word = {mem[hi_idx(rd_addr)], mem[lo_idx(rd_addr)]};
    else        rd_word = {8'h00, mem[rd_addr]};
  end

endmodule

// File: rtl/mw_eeprom_busy.sv
module mw_eeprom_busy #(
  parameter int BUSY_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left <= '0;
    else if (start)         left <= CW'(BUSY_CYCLES);
    else if (left != '0)    left <= left - 1'b1;
  end

  assign busy = (left != '0);

endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int BYTE_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide16,
  input  logic               sel,
  input  logic               sclk,
  input  logic               sdi,
  input  logic               busy,
  input  logic [15:0]        rd_word,
  output logic [BYTE_AW-1:0] rd_addr,
  output logic               wr_go,
  output logic [BYTE_AW-1:0] wr_addr,
  output logic [15:0]        wr_data,
  output logic               sdo,
  output logic               sdo_en,
  output logic               wen,
  output logic               cmd_start,
  output logic               rd_active,
  output logic               unlock_ev,
  output logic               lock_ev
);
  localparam int FRAME_W = BYTE_AW + 1;
  localparam int CNT_W   = $clog2(16 + FRAME_W);

  function automatic logic [CNT_W-1:0] addr_len(input logic w16);
    return w16 ? CNT_W'(BYTE_AW) : CNT_W'(FRAME_W);
  endfunction

  function automatic logic [CNT_W-1:0] word_len(input logic w16);
    return w16 ? CNT_W'(16) : CNT_W'(8);
  endfunction

  function automatic logic [BYTE_AW-1:0] pick_addr(input logic [FRAME_W-1:0] f,
                                                    input logic w16);
    return w16 ? {1'b0, f[BYTE_AW-2:0]} : f[BYTE_AW-1:0];
  endfunction

  function automatic logic [1:0] pick_ctl(input logic [FRAME_W-1:0] f, input logic w16);
    return w16 ? f[BYTE_AW-1 -: 2] : f[FRAME_W-1 -: 2];
  endfunction

  function automatic logic [BYTE_AW-1:0] step_addr(input logic [BYTE_AW-1:0] a,
                                                    input logic w16);
    logic [BYTE_AW-2:0] wa;
    wa = a[BYTE_AW-2:0] + 1'b1;
    return w16 ? {1'b0, wa} : a + 1'b1;
  endfunction

  mw_state_e          state;
  logic               sclk_q;
  logic [1:0]         opc;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] addr_sh;
  logic [15:0]        data_sh;
  logic [3:0]         bit_ptr;
  logic               do_bit;
  logic               armed;
  logic               stat_show;

  logic               rise;
  logic               step;
  logic [FRAME_W-1:0] frame_nx;
  logic [15:0]        data_nx;
  logic               addr_last;
  logic               data_last;

  assign rise      = sclk & ~sclk_q;
  assign step      = sel & rise & ~busy;
  assign frame_nx  = {addr_sh[FRAME_W-2:0], sdi};
  assign data_nx   = {data_sh[14:0], sdi};
  assign addr_last = (cnt == addr_len(wide16) - 1'b1);
  assign data_last = (cnt == word_len(wide16) - 1'b1);

  assign cmd_start = step & (state == ST_IDLE) & sdi;
  assign unlock_ev = step & (state == ST_ADDR) & addr_last & (opc == OP_CTL) &
                     (pick_ctl(frame_nx, wide16) == CTL_UNLOCK);
  assign lock_ev   = step & (state == ST_ADDR) & addr_last & (opc == OP_CTL) &
                     (pick_ctl(frame_nx, wide16) == CTL_LOCK);
  assign wr_go     = armed & ~sel;
  assign rd_active = (state == ST_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sclk_q    <= 1'b0;
      opc       <= '0;
      cnt       <= '0;
      addr_sh   <= '0;
      data_sh   <= '0;
      bit_ptr   <= '0;
      do_bit    <= 1'b0;
      armed     <= 1'b0;
      stat_show <= 1'b0;
      wen       <= 1'b0;
      rd_addr   <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      sclk_q <= sclk;
      if (!sel) begin
        state <= ST_IDLE;
        armed <= 1'b0;
        if (wr_go) stat_show <= 1'b1;
      end else if (step) begin
        unique case (state)
          ST_IDLE: begin
            if (sdi) begin
              state     <= ST_OPC;
              cnt       <= '0;
              stat_show <= 1'b0;
            end
          end
          ST_OPC: begin
            opc <= {opc[0], sdi};
            if (cnt == CNT_W'(1)) begin
              state   <= ST_ADDR;
              cnt     <= '0;
              addr_sh <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: begin
            addr_sh <= frame_nx;
            if (addr_last) begin
              cnt <= '0;
              unique case (opc)
                OP_RD: begin
                  rd_addr <= pick_addr(frame_nx, wide16);
                  bit_ptr <= 4'(word_len(wide16) - 1'b1);
                  do_bit  <= 1'b0;
                  state   <= ST_READ;
                end
                OP_WR: begin
                  wr_addr <= pick_addr(frame_nx, wide16);
                  data_sh <= '0;
                  state   <= ST_DATA;
                end
                OP_CTL: begin
                  if (unlock_ev)    wen <= 1'b1;
                  else if (lock_ev) wen <= 1'b0;
                  state <= ST_HOLD;
                end
                default: state <= ST_HOLD;
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            data_sh <= data_nx;
            if (data_last) begin
              if (wen) begin
                armed   <= 1'b1;
                wr_data <= wide16 ? data_nx : {8'h00, data_nx[7:0]};
              end
              state <= ST_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_READ: begin
            do_bit <= rd_word[bit_ptr];
            if (bit_ptr == 4'd0) begin
              bit_ptr <= 4'(word_len(wide16) - 1'b1);
              rd_addr <= step_addr(rd_addr, wide16);
            end else begin
              bit_ptr <= bit_ptr - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdo_en = sel & ((state == ST_READ) | ((state == ST_IDLE) & stat_show));
  assign sdo    = (state == ST_READ) ? do_bit : ~busy;

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int BYTE_AW     = 8,
  parameter int BUSY_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wide16,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en
);
  logic [BYTE_AW-1:0] rd_addr;
  logic [BYTE_AW-1:0] wr_addr;
  logic [15:0]        wr_data;
  logic [15:0]        rd_word;
  logic               wr_go;
  logic               busy;
  logic               wen;
  logic               cmd_start;
  logic               rd_active;
  logic               unlock_ev;
  logic               lock_ev;

  mw_eeprom_ctrl #(.BYTE_AW(BYTE_AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide16    (wide16),
    .sel       (sel),
    .sclk      (sclk),
    .sdi       (sdi),
    .busy      (busy),
    .rd_word   (rd_word),
    .rd_addr   (rd_addr),
    .wr_go     (wr_go),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sdo       (sdo),
    .sdo_en    (sdo_en),
    .wen       (wen),
    .cmd_start (cmd_start),
    .rd_active (rd_active),
    .unlock_ev (unlock_ev),
    .lock_ev   (lock_ev)
  );

  mw_eeprom_array #(.BYTE_AW(BYTE_AW)) u_array (
    .clk     (clk),
    .wide16  (wide16),
    .rd_addr (rd_addr),
    .wr_en   (wr_go),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_word (rd_word)
  );

  mw_eeprom_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wr_go),
    .busy  (busy)
  );

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic sdo,
  input logic sdo_en,
  input logic wen,
  input logic wr_go,
  input logic busy,
  input logic cmd_start,
  input logic rd_active,
  input logic unlock_ev,
  input logic lock_ev
);

  p_drive_needs_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> sel);

  p_dummy_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> (sdo_en && !sdo));

  p_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_ev |=> wen);

  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ev |=> !wen);

  p_commit_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> wen);

  p_busy_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> busy);

  p_status_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en && !rd_active && busy) |-> !sdo);

  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_start);

endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel       (sel),
  .sdo       (sdo),
  .sdo_en    (sdo_en),
  .wen       (wen),
  .wr_go     (wr_go),
  .busy      (busy),
  .cmd_start (cmd_start),
  .rd_active (rd_active),
  .unlock_ev (unlock_ev),
  .lock_ev   (lock_ev)
);

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
  localparam int T_BUSY = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide16 = 1'b1;
  logic sel = 1'b0;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  logic sdo_en;

  int total = 0;
  int bad = 0;
  logic [15:0] rbuf [4];
  logic dummy_ok;

  always #4 clk = ~clk;

  mw_eeprom #(.BYTE_AW(8), .BUSY_CYCLES(T_BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .wide16(wide16), .sel(sel),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clk_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    @(negedge clk) sdi = b;
    clk_wait(2); sclk = 1'b1;
    clk_wait(2); sclk = 1'b0;
    clk_wait(1);
  endtask

  task automatic pulse_rd(output logic o);
    @(negedge clk) sdi = 1'b0;
    sclk = 1'b1;
    clk_wait(2); o = sdo;
    sclk = 1'b0;
    clk_wait(2);
  endtask

  task automatic begin_cmd();
    @(negedge clk) sel = 1'b1;
    clk_wait(2);
  endtask

  task automatic end_cmd();
    @(negedge clk) sel = 1'b0;
    clk_wait(3);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [8:0] a);
    int n = wide16 ? 8 : 9;
    pulse(1'b1);
    pulse(op[1]);
    pulse(op[0]);
    for (int i = n - 1; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic send_data(input logic [15:0] d);
    int n = wide16 ? 16 : 8;
    for (int i = n - 1; i >= 0; i--) pulse(d[i]);
  endtask

  task automatic ctl(input logic [1:0] code);
    begin_cmd();
    hdr(2'b00, wide16 ? {1'b0, code, 6'd0} : {code, 7'd0});
    end_cmd();
  endtask

  task automatic write_word(input logic [8:0] a, input logic [15:0] d);
    begin_cmd();
    hdr(2'b01, a);
    send_data(d);
    end_cmd();
  endtask

  task automatic read_words(input logic [8:0] a, input int n);
    int wb = wide16 ? 16 : 8;
    begin_cmd();
    hdr(2'b10, a);
    dummy_ok = sdo_en && (sdo == 1'b0);
    for (int w = 0; w < n; w++) begin
      rbuf[w] = '0;
      for (int b = 0; b < wb; b++) begin
        logic o;
        pulse_rd(o);
        rbuf[w] = {rbuf[w][14:0], o};
      end
    end
    end_cmd();
  endtask

  task automatic t_reset();
    chk("R11 reset sel low drive", {31'd0, sdo_en}, 0);
    begin_cmd();
    chk("R11 idle sel high drive", {31'd0, sdo_en}, 0);
    end_cmd();
  endtask

  task automatic t_locked_after_reset();
    write_word(9'd3, 16'h1111);
    begin_cmd();
    chk("R7 no status after locked write", {31'd0, sdo_en}, 0);
    end_cmd();
  endtask

  task automatic t_write_busy();
    ctl(2'b11);
    begin_cmd();
    hdr(2'b01, 9'd3);
    send_data(16'hBEEF);
    @(negedge clk) sel = 1'b0;
    clk_wait(3);
    @(negedge clk) sel = 1'b1;
    clk_wait(2);
    chk("R9 status driven", {31'd0, sdo_en}, 1);
    chk("R9 busy early", {31'd0, sdo}, 0);
    clk_wait(T_BUSY - 20);
    chk("R9 busy late", {31'd0, sdo}, 0);
    clk_wait(30);
    chk("R9 ready", {31'd0, sdo}, 1);
    end_cmd();
  endtask

  task automatic t_read_single();
    read_words(9'd3, 1);
    chk("R3 dummy zero", {31'd0, dummy_ok}, 1);
    chk("R3 R8 word 3", {16'd0, rbuf[0]}, 32'hBEEF);
    read_words(9'h083, 1);
    chk("R1 top address bit ignored", {16'd0, rbuf[0]}, 32'hBEEF);
  endtask

  task automatic t_stream();
    write_word(9'd4, 16'h1357);
    clk_wait(T_BUSY + 5);
    read_words(9'd3, 2);
    chk("R4 stream first", {16'd0, rbuf[0]}, 32'hBEEF);
    chk("R4 stream second no gap", {16'd0, rbuf[1]}, 32'h1357);
  endtask

  task automatic t_wrap16();
    write_word(9'd127, 16'hA001);
    clk_wait(T_BUSY + 5);
    write_word(9'd0, 16'h5AA5);
    clk_wait(T_BUSY + 5);
    read_words(9'd127, 2);
    chk("R5 last word", {16'd0, rbuf[0]}, 32'hA001);
    chk("R5 wrap to 0", {16'd0, rbuf[1]}, 32'h5AA5);
  endtask

  task automatic t_busy_ignore();
    write_word(9'd10, 16'h0F0F);
    begin_cmd();
    hdr(2'b10, 9'd3);
    chk("R10 read not started while busy", {30'd0, sdo_en, sdo}, 32'h2);
    pulse(1'b0);
    chk("R10 still busy status", {30'd0, sdo_en, sdo}, 32'h2);
    end_cmd();
    clk_wait(T_BUSY + 5);
    read_words(9'd10, 1);
    chk("R8 word 10 stored", {16'd0, rbuf[0]}, 32'h0F0F);
  endtask

  task automatic t_lock();
    ctl(2'b00);
    write_word(9'd3, 16'h0000);
    begin_cmd();
    chk("R6 lock blocks write status", {31'd0, sdo_en}, 0);
    end_cmd();
    read_words(9'd3, 1);
    chk("R12 read while locked", {16'd0, rbuf[0]}, 32'hBEEF);
    ctl(2'b01);
    write_word(9'd3, 16'h0000);
    read_words(9'd3, 1);
    chk("R6 code 01 leaves latch clear", {16'd0, rbuf[0]}, 32'hBEEF);
  endtask

  task automatic t_abort();
    ctl(2'b11);
    begin_cmd();
    hdr(2'b01, 9'd3);
    for (int i = 0; i < 8; i++) pulse(1'b0);
    end_cmd();
    begin_cmd();
    chk("R8 partial write no status", {31'd0, sdo_en}, 0);
    end_cmd();
    read_words(9'd3, 1);
    chk("R8 partial write stored nothing", {16'd0, rbuf[0]}, 32'hBEEF);
    begin_cmd();
    hdr(2'b10, 9'd3);
    @(negedge clk) sel = 1'b0;
    clk_wait(1);
    chk("R11 read aborted hi-z", {31'd0, sdo_en}, 0);
    clk_wait(2);
  endtask

  task automatic t_bytes();
    @(negedge clk) wide16 = 1'b0;
    clk_wait(2);
    read_words(9'd6, 3);
    chk("R1 byte 6 upper of word 3", {24'd0, rbuf[0][7:0]}, 32'hBE);
    chk("R1 byte 7 lower of word 3", {24'd0, rbuf[1][7:0]}, 32'hEF);
    chk("R4 byte stream 8", {24'd0, rbuf[2][7:0]}, 32'h13);
    ctl(2'b11);
    write_word(9'd255, 16'h003C);
    clk_wait(T_BUSY + 5);
    read_words(9'h1FF, 2);
    chk("R5 byte 255", {24'd0, rbuf[0][7:0]}, 32'h3C);
    chk("R5 byte wrap to 0", {24'd0, rbuf[1][7:0]}, 32'h5A);
  endtask

  initial begin
    clk_wait(4);
    rst_n = 1'b1;
    clk_wait(2);
    t_reset();
    t_locked_after_reset();
    t_write_busy();
    t_read_single();
    t_stream();
    t_wrap16();
    t_busy_ignore();
    t_lock();
    t_abort();
    t_bytes();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R2 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule